// File: doc/BRIEF.md
# Demultiplexed 16-bit Parallel Slave Port

This block is the device side of a parallel host bus with separate address and data buses. The host selects the port with an active-high select line, which is tied high when the host does not use it. A single direction line chooses between read and write. Two byte-lane strobes carry the timing. The port turns each strobe period into one internal memory request. A read produces a single-cycle read request. A write produces a single-cycle write request that carries address, data and a 2-bit byte-enable mask.

Every host control line passes through a synchroniser before edge detection. The data-bus output enable is a combinational function of the raw pins, so the port claims the bus as soon as a read strobe rises. It first drives zero. It switches to the fetched word once an access latency of `RD_WAIT` clocks has run out. The bus is modelled as a separate input, an output and an output enable.

Top module: `pslave_port`

## Requirements
- R1: After reset, `host_data_oe`, `mem_rd_req` and `mem_wr_req` are low and `host_data_out` is zero.
- R2: `host_data_oe` is high exactly while `host_sel` is high, `host_rnw` is high and at least one bit of `host_lane_stb` is high. In every other case, including a select line that is low, a direction line that is low, or both strobes low, the bus is released.
- R3: A read strobe period (`host_rnw` high when the first strobe rises) issues exactly one single-cycle `mem_rd_req`, with `mem_addr` equal to `host_addr`.
- R4: During a read, `host_data_out` is zero until the access latency has elapsed. It then carries the full 16-bit word from memory, whichever of the lanes is strobed.
- R5: The read word stays on `host_data_out` unchanged until both strobes are low.
- R6: A write strobe period issues exactly one single-cycle `mem_wr_req` after both strobes have fallen. It carries the `host_addr` and `host_data_in` values present at that fall. Read and write requests are never high together.
- R7: `host_lane_stb` bit 0 is the low lane (data bits 7:0) and maps to `mem_be` bit 0. Bit 1 is the high lane (bits 15:8) and maps to `mem_be` bit 1. The mask is the union of all lanes strobed during the period, so it is never zero on a write.
- R8: While `host_sel` is low, strobes cause no memory request.
- R9: The direction is fixed when the first strobe rises. A later change on `host_rnw` within the same strobe period does not turn a read into a write.
- R10: All 14 address bits are passed through, including addresses whose upper 6 bits are tied high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Port select, active high |
| host_rnw | input | 1 | Direction: 1 read, 0 write |
| host_lane_stb | input | 2 | Byte-lane strobes, bit 0 low lane, bit 1 high lane |
| host_addr | input | 14 | Host address bus |
| host_data_in | input | 16 | Data bus as seen from the pins |
| host_data_out | output | 16 | Data driven onto the bus on reads |
| host_data_oe | output | 1 | Bus output enable |
| mem_rd_req | output | 1 | Single-cycle memory read request |
| mem_wr_req | output | 1 | Single-cycle memory write request |
| mem_addr | output | 14 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Write byte enables |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read request |

## Verification
A stuck or wrong phase register shows up at the memory side within about four clocks of a strobe edge. It appears as a missing or doubled request, or as a read that turns into a write. A wrong lane accumulator corrupts the byte mask of the very next write, and the later read-back of that word exposes it. A latency counter fault shows either as a word that is still zero well after the access time, or as a word that changes while the strobe is held. Every read in the sweep checks for both.

// File: rtl/pslave_pkg.sv
package pslave_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/pslave_sync.sv
module pslave_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_in;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pslave_bus_drv.sv
module pslave_bus_drv #(
    parameter int N_LANES = 2,
    parameter int DATA_W  = 16
) (
    input  logic               host_sel,
    input  logic               host_rnw,
    input  logic [N_LANES-1:0] host_lane_stb,
    input  logic               word_valid,
    input  logic [DATA_W-1:0]  word,
    output logic               bus_oe,
    output logic [DATA_W-1:0]  bus_out
);
    // Enable follows the raw pins so the bus is claimed without delay.
    assign bus_oe  = host_sel & host_rnw & (|host_lane_stb);
    assign bus_out = word_valid ? word : '0;
endmodule

// File: rtl/pslave_port.sv
module pslave_port
    import pslave_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int LANE_W      = 8,
    parameter int N_LANES     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int RD_WAIT     = 4,
    localparam int DATA_W     = LANE_W * N_LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_rnw,
    input  logic [N_LANES-1:0] host_lane_stb,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_data_in,
    output logic [DATA_W-1:0]  host_data_out,
    output logic               host_data_oe,
    output logic               mem_rd_req,
    output logic               mem_wr_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [N_LANES-1:0] mem_be,
    input  logic [DATA_W-1:0]  mem_rdata
);
    localparam int CNT_W  = $clog2(RD_WAIT + 1);
    localparam int CTRL_W = N_LANES + 2;

    typedef struct packed {
        phase_e             phase;
        logic [N_LANES-1:0] lanes;
        logic               rd_req;
        logic               wr_req;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [N_LANES-1:0] be;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  rdata;
        logic               valid;
    } state_t;

    state_t state_d, state_q;

    logic [CTRL_W-1:0]  ctrl_s;
    logic               sel_s, rnw_s, active;
    logic [N_LANES-1:0] stb_s;

    pslave_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({host_sel, host_rnw, host_lane_stb}),
        .q_out (ctrl_s)
    );

    assign {sel_s, rnw_s, stb_s} = ctrl_s;
    assign active = sel_s & (|stb_s);

    always_comb begin
        state_d        = state_q;
        state_d.rd_req = 1'b0;
        state_d.wr_req = 1'b0;
        unique case (state_q.phase)
            PH_IDLE: begin
                if (active) begin
                    if (rnw_s) begin
                        state_d.phase  = PH_READ;
                        state_d.rd_req = 1'b1;
                        state_d.addr   = host_addr;
                        state_d.cnt    = CNT_W'(RD_WAIT);
                        state_d.valid  = 1'b0;
                    end else begin
                        state_d.phase = PH_WRITE;
                        state_d.lanes = stb_s;
                    end
                end
            end
            PH_READ: begin
                if (!active) begin
                    state_d.phase = PH_IDLE;
                    state_d.valid = 1'b0;
                    state_d.cnt   = '0;
                end else if (state_q.cnt != '0) begin
                    state_d.cnt = state_q.cnt - CNT_W'(1);
                    if (state_q.cnt == CNT_W'(1)) begin
                        state_d.rdata = mem_rdata;
                        state_d.valid = 1'b1;
                    end
                end
            end
            PH_WRITE: begin
                if (!active) begin
                    state_d.phase  = PH_IDLE;
                    state_d.wr_req = 1'b1;
                    state_d.addr   = host_addr;
                    state_d.wdata  = host_data_in;
                    state_d.be     = state_q.lanes;
                end else begin
                    state_d.lanes = state_q.lanes | stb_s;
                end
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.phase <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    pslave_bus_drv #(.N_LANES(N_LANES), .DATA_W(DATA_W)) i_drv (
        .host_sel      (host_sel),
        .host_rnw      (host_rnw),
        .host_lane_stb (host_lane_stb),
        .word_valid    (state_q.valid),
        .word          (state_q.rdata),
        .bus_oe        (host_data_oe),
        .bus_out       (host_data_out)
    );

    assign mem_rd_req = state_q.rd_req;
    assign mem_wr_req = state_q.wr_req;
    assign mem_addr   = state_q.addr;
    assign mem_wdata  = state_q.wdata;
    assign mem_be     = state_q.be;
endmodule

// File: rtl/pslave_port_chk.sv
module pslave_port_chk #(
    parameter int N_LANES = 2,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_data_oe,
    input logic [DATA_W-1:0]  host_data_out,
    input logic               mem_rd_req,
    input logic               mem_wr_req,
    input logic [N_LANES-1:0] mem_be
);
    // R3
    rd_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R6
    wr_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |=> !mem_wr_req);

    // R6
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    // R7
    be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (mem_be != '0));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_oe && $past(host_data_oe) && ($past(host_data_out) != '0))
            |-> $stable(host_data_out));
endmodule

bind pslave_port pslave_port_chk #(.N_LANES(N_LANES), .DATA_W(DATA_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_data_oe  (host_data_oe),
    .host_data_out (host_data_out),
    .mem_rd_req    (mem_rd_req),
    .mem_wr_req    (mem_wr_req),
    .mem_be        (mem_be)
);

// File: tb/test_pslave_port.sv
module test_pslave_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b1, rnw = 1'b0;
    logic [1:0]  stb = 2'b00;
    logic [13:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout, wdata, rdata;
    logic        oe, rd_req, wr_req;
    logic [13:0] maddr;
    logic [1:0]  be;

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_rd = 0;
    logic [13:0] last_waddr, last_raddr;
    logic [15:0] last_wdata;
    logic [1:0]  last_be;
    logic [15:0] mem [0:255];
    logic [15:0] exp_mem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    pslave_port i_pslave_port (
        .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_rnw(rnw),
        .host_lane_stb(stb), .host_addr(addr), .host_data_in(din),
        .host_data_out(dout), .host_data_oe(oe), .mem_rd_req(rd_req),
        .mem_wr_req(wr_req), .mem_addr(maddr), .mem_wdata(wdata),
        .mem_be(be), .mem_rdata(rdata)
    );

    // Memory model and request monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (wr_req) begin
                if (be[0]) mem[maddr[7:0]][7:0]  <= wdata[7:0];
                if (be[1]) mem[maddr[7:0]][15:8] <= wdata[15:8];
                n_wr <= n_wr + 1;
                last_waddr <= maddr; last_wdata <= wdata; last_be <= be;
            end
            if (rd_req) begin
                rdata <= mem[maddr[7:0]];
                n_rd <= n_rd + 1;
                last_raddr <= maddr;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int a, input int ln);
        return 16'((a * 16'h0101 + ln * 16'h1357) ^ 16'hA5C3);
    endfunction

    task automatic do_write(input logic [13:0] a, input logic [15:0] d, input logic [1:0] ln);
        int w0;
        w0 = n_wr;
        @(negedge clk); sel = 1'b1; rnw = 1'b0; addr = a; din = d;
        @(negedge clk); stb = ln; #1;
        chk("R2 oe during write", 32'(oe), 32'(0));
        repeat (6) @(negedge clk); stb = 2'b00;
        repeat (6) @(negedge clk);
        chk("R6 write count", 32'(n_wr - w0), 32'(1));
        chk("R6 write addr", 32'(last_waddr), 32'(a));
        chk("R6 write data", 32'(last_wdata), 32'(d));
        chk("R7 byte enables", 32'(last_be), 32'(ln));
        if (ln[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
        if (ln[1]) exp_mem[a[7:0]][15:8] = d[15:8];
    endtask

    task automatic do_read(input logic [13:0] a, input logic [1:0] ln);
        int r0;
        logic [15:0] w;
        r0 = n_rd;
        @(negedge clk); sel = 1'b1; rnw = 1'b1; addr = a;
        @(negedge clk); stb = ln; #1;
        chk("R2 oe on read strobe", 32'(oe), 32'(1));
        chk("R4 zero before latency", 32'(dout), 32'(0));
        repeat (12) @(negedge clk);
        chk("R4 full word", 32'(dout), 32'(exp_mem[a[7:0]]));
        chk("R3 read count", 32'(n_rd - r0), 32'(1));
        chk("R3 read addr", 32'(last_raddr), 32'(a));
        w = dout;
        repeat (8) @(negedge clk);
        chk("R5 word held", 32'(dout), 32'(w));
        stb = 2'b00; #1;
        chk("R2 released", 32'(oe), 32'(0));
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w0, r0;
        for (int i = 0; i < 256; i++) exp_mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 oe", 32'(oe), 32'(0));
        chk("R1 dout", 32'(dout), 32'(0));
        chk("R1 rd_req", 32'(rd_req), 32'(0));
        chk("R1 wr_req", 32'(wr_req), 32'(0));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Sweep of addresses and lane masks (R3 R4 R6 R7)
        for (int a = 0; a < 32; a++) begin
            for (int ln = 1; ln < 4; ln++) do_write(14'(a), pat(a, ln), 2'(ln));
            do_read(14'(a), 2'((a % 3) + 1));
        end

        // R10 upper address bits tied high
        for (int k = 0; k < 8; k++) begin
            do_write(14'h3F00 | 14'(32 + k), pat(k, 7), 2'b11);
            do_read(14'h3F00 | 14'(32 + k), 2'b01);
        end

        // R7 staggered lanes form the union mask
        w0 = n_wr;
        @(negedge clk); rnw = 1'b0; addr = 14'd50; din = 16'hBEEF;
        @(negedge clk); stb = 2'b01;
        repeat (3) @(negedge clk); stb = 2'b11;
        repeat (3) @(negedge clk); stb = 2'b10;
        repeat (3) @(negedge clk); stb = 2'b00;
        repeat (6) @(negedge clk);
        chk("R7 staggered count", 32'(n_wr - w0), 32'(1));
        chk("R7 staggered mask", 32'(last_be), 32'(2'b11));
        exp_mem[50] = 16'hBEEF;
        do_read(14'd50, 2'b10);

        // R8 deselected port
        w0 = n_wr; r0 = n_rd;
        @(negedge clk); sel = 1'b0; rnw = 1'b0; addr = 14'd51; din = 16'h1234;
        @(negedge clk); stb = 2'b11;
        repeat (6) @(negedge clk); stb = 2'b00;
        repeat (6) @(negedge clk);
        rnw = 1'b1;
        @(negedge clk); stb = 2'b01; #1;
        chk("R2 deselected read oe", 32'(oe), 32'(0));
        repeat (6) @(negedge clk); stb = 2'b00;
        repeat (6) @(negedge clk);
        chk("R8 no write", 32'(n_wr - w0), 32'(0));
        chk("R8 no read", 32'(n_rd - r0), 32'(0));
        sel = 1'b1;

        // R9 direction fixed at first strobe
        w0 = n_wr; r0 = n_rd;
        @(negedge clk); rnw = 1'b1; addr = 14'd5;
        @(negedge clk); stb = 2'b01;
        repeat (6) @(negedge clk); rnw = 1'b0; #1;
        chk("R2 oe low with rnw low", 32'(oe), 32'(0));
        repeat (4) @(negedge clk); stb = 2'b00;
        repeat (6) @(negedge clk);
        chk("R9 no write", 32'(n_wr - w0), 32'(0));
        chk("R9 one read", 32'(n_rd - r0), 32'(1));
        do_read(14'd5, 2'b11);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule